// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Slave

This block is the addressing layer of a slave on a single-wire bus. A bit-slot front end below it turns line activity into three kinds of event: a bus-reset pulse, a strobe carrying one bit written by the master, and a request for the bit the slave returns in a read slot. The block holds a fixed 64-bit identifier made of a family code, a serial number and a check byte. After each bus reset it collects one command byte and then carries out an identifier operation: read it out, compare it, skip it, or take part in bitwise search arbitration. A second search variant admits only slaves that have an interrupt waiting.

When an identifier operation finishes successfully, the block raises `grant`. This tells the layer above that the following bytes belong to the memory-function layer. If a comparison fails, a search choice goes against this slave, or the command byte is unknown, the block falls silent until the next bus reset.

`tx_bit` always shows the bit that the next read slot will return. The value 1 means the line is left released. A `tx_req` pulse consumes that bit.

Top module: `ow_rom_slave`

## Requirements
- R1: A `bus_reset` pulse, or `rst`, at any moment returns the block to waiting for a command byte. In that state `grant` is 0 and `tx_bit` is 1, and any command bits already collected are discarded.
- R2: The identifier is built as follows. Bits 7:0 hold the family code 04h. Bits 55:8 hold the serial number. Bits 63:56 hold a CRC of bits 55:0, computed with polynomial x^8+x^5+x^4+1 from a zero start, bit 0 first. Running all 64 bits through that CRC leaves zero.
- R3: A command byte is taken from eight received bits, least significant first. The recognised codes are 33h (read), 55h (match), CCh (skip), F0h (search) and ECh (conditional search).
- R4: After 33h, the 64 identifier bits are returned over 64 read slots, bit 0 first. `grant` rises after the last of them.
- R5: After 55h, 64 received bits are compared with the identifier, bit 0 first. If all match, `grant` rises. On the first mismatch the slave goes silent until a bus reset.
- R6: After CCh, `grant` rises without any identifier traffic.
- R7: After F0h, each identifier bit is handled in three steps: a read slot returns the bit, a second read slot returns its complement, and then one received bit carries the master's choice. A choice that differs from the slave's own bit makes it go silent until reset. After 64 bits, `grant` rises.
- R8: ECh behaves like F0h, but only while `irq_pending` is 1. If it is 0 when the command completes, or if it drops during the search, the slave goes silent until reset.
- R9: Any other command byte makes the slave go silent until reset. While silent, received bits have no effect and `grant` stays 0.
- R10: While silent, while waiting for a command, and while granted, every read slot returns 1.
- R11: Once raised, `grant` stays 1 until a bus reset. Received bits and read slots during that time do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle pulse: the front end saw a bus reset |
| rx_valid | input | 1 | One-cycle strobe: a master-written bit arrived |
| rx_bit | input | 1 | Value of the bit strobed by `rx_valid` |
| tx_req | input | 1 | One-cycle pulse: a read slot consumes `tx_bit` |
| tx_bit | output | 1 | Bit for the next read slot (1 = line released) |
| irq_pending | input | 1 | An interrupt is pending and not yet acknowledged |
| grant | output | 1 | Identifier phase done; later bytes go to the memory layer |

## Verification
A wrong internal state shows up quickly at the ports. A misplaced bit index or an off-by-one in the command count corrupts the very next `tx_bit` value that is read, and the `grant` timing after 64 bits is off by at least one slot. A slave that fails to drop out keeps returning identifier bits instead of 1 in the next read slot. A missed reset leaves `grant` high, or leaves the following command byte misaligned, so that the next skip command fails to grant. Every such fault is visible within one bit time of the stimulus that should have caused the change.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    localparam int ID_W   = 64;
    localparam int BODY_W = 56;
    localparam int CMD_W  = 8;
    localparam int IDX_W  = $clog2(ID_W);
    localparam int CNT_W  = $clog2(CMD_W);

    localparam logic [CMD_W-1:0] OP_READ    = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH   = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP    = 8'hCC;
    localparam logic [CMD_W-1:0] OP_SEARCH  = 8'hF0;
    localparam logic [CMD_W-1:0] OP_CSEARCH = 8'hEC;

    // reflected form of x^8+x^5+x^4+1
    localparam logic [7:0] CRC_POLY_R = 8'h8C;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_GRANT,
        ST_IDLE
    } rom_state_e;

    typedef enum logic [1:0] {
        SP_TRUE,
        SP_COMP,
        SP_PICK
    } srch_phase_e;

    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        logic [7:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ CRC_POLY_R;
        return n;
    endfunction

    function automatic logic [7:0] crc8_body(input logic [BODY_W-1:0] d);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < BODY_W; i++) c = crc8_step(c, d[i]);
        return c;
    endfunction

endpackage

// File: rtl/owrom_id_store.sv
module owrom_id_store
    import owrom_pkg::*;
#(
    parameter logic [7:0]  FAMILY_CODE = 8'h04,
    parameter logic [47:0] SERIAL_NUM  = 48'h1A2B3C4D5E6F
) (
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);
    localparam logic [BODY_W-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};
    localparam logic [7:0]        CHK  = crc8_body(BODY);
    localparam logic [ID_W-1:0]   FULL = {CHK, BODY};

    assign id_bit = FULL[idx];

endmodule

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx
    import owrom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             rx_valid,
    input  logic             rx_bit,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_byte
);
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt       <= '0;
            shreg     <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (en && rx_valid) begin
                shreg <= {rx_bit, shreg[CMD_W-1:1]};
                if (cnt == CNT_W'(CMD_W - 1)) begin
                    cnt       <= '0;
                    cmd_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign cmd_byte = shreg;

    // R3
    cmd_from_bit_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(rx_valid && en));

endmodule

// File: rtl/owrom_ctrl.sv
module owrom_ctrl
    import owrom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             tx_req,
    input  logic             irq_pending,
    input  logic             id_bit,
    output logic [IDX_W-1:0] idx,
    output logic             cmd_en,
    output logic             tx_bit,
    output logic             grant
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_W - 1);

    rom_state_e  state;
    srch_phase_e phase;
    logic        cond;

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            state <= ST_CMD;
            idx   <= '0;
            phase <= SP_TRUE;
            cond  <= 1'b0;
        end else begin
            case (state)
                ST_CMD: if (cmd_valid) begin
                    idx   <= '0;
                    phase <= SP_TRUE;
                    case (cmd_byte)
                        OP_READ:    state <= ST_READ;
                        OP_MATCH:   state <= ST_MATCH;
                        OP_SKIP:    state <= ST_GRANT;
                        OP_SEARCH: begin
                            state <= ST_SEARCH;
                            cond  <= 1'b0;
                        end
                        OP_CSEARCH: begin
                            state <= irq_pending ? ST_SEARCH : ST_IDLE;
                            cond  <= 1'b1;
                        end
                        default:    state <= ST_IDLE;
                    endcase
                end
                ST_READ: if (tx_req) begin
                    if (idx == LAST) state <= ST_GRANT;
                    else             idx   <= idx + 1'b1;
                end
                ST_MATCH: if (rx_valid) begin
                    if (rx_bit != id_bit) state <= ST_IDLE;
                    else if (idx == LAST) state <= ST_GRANT;
                    else                  idx   <= idx + 1'b1;
                end
                ST_SEARCH: begin
                    if (cond && !irq_pending) begin
                        state <= ST_IDLE;
                    end else begin
                        case (phase)
                            SP_TRUE: if (tx_req) phase <= SP_COMP;
                            SP_COMP: if (tx_req) phase <= SP_PICK;
                            default: if (rx_valid) begin
                                phase <= SP_TRUE;
                                if (rx_bit != id_bit) state <= ST_IDLE;
                                else if (idx == LAST) state <= ST_GRANT;
                                else                  idx   <= idx + 1'b1;
                            end
                        endcase
                    end
                end
                default: state <= state;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_READ:   tx_bit = id_bit;
            ST_SEARCH: begin
                case (phase)
                    SP_TRUE: tx_bit = id_bit;
                    SP_COMP: tx_bit = ~id_bit;
                    default: tx_bit = 1'b1;
                endcase
            end
            default:   tx_bit = 1'b1;
        endcase
    end

    assign grant  = (state == ST_GRANT);
    assign cmd_en = (state == ST_CMD);

    // R1
    bus_reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (!grant && cmd_en));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !bus_reset) |=> (state == ST_IDLE && !grant));

    // R11
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && !bus_reset) |=> grant);

    // R7
    search_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEARCH && phase == SP_PICK && rx_valid && !bus_reset
         && (rx_bit != id_bit)) |=> (state == ST_IDLE));

endmodule

// File: rtl/ow_rom_slave.sv
module ow_rom_slave
    import owrom_pkg::*;
#(
    parameter logic [7:0]  FAMILY_CODE = 8'h04,
    parameter logic [47:0] SERIAL_NUM  = 48'h1A2B3C4D5E6F
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic tx_req,
    output logic tx_bit,
    input  logic irq_pending,
    output logic grant
);
    logic             cmd_valid;
    logic [CMD_W-1:0] cmd_byte;
    logic [IDX_W-1:0] idx;
    logic             id_bit;
    logic             cmd_en;

    owrom_id_store #(
        .FAMILY_CODE(FAMILY_CODE),
        .SERIAL_NUM (SERIAL_NUM)
    ) u_id (
        .idx   (idx),
        .id_bit(id_bit)
    );

    owrom_cmd_rx u_cmd (
        .clk      (clk),
        .rst      (rst),
        .clr      (bus_reset),
        .en       (cmd_en),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit),
        .cmd_valid(cmd_valid),
        .cmd_byte (cmd_byte)
    );

    owrom_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit),
        .tx_req     (tx_req),
        .irq_pending(irq_pending),
        .id_bit     (id_bit),
        .idx        (idx),
        .cmd_en     (cmd_en),
        .tx_bit     (tx_bit),
        .grant      (grant)
    );

    // R10
    released_when_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && !bus_reset) |=> (cmd_en |-> tx_bit));

endmodule

// File: tb/ow_rom_slave_test.sv
module ow_rom_slave_test;

    localparam logic [7:0]  FAM = 8'h04;
    localparam logic [47:0] SER = 48'h1A2B3C4D5E6F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic tx_req = 1'b0;
    logic irq_pending = 1'b0;
    logic tx_bit;
    logic grant;

    int checks = 0;
    int fails  = 0;
    logic [63:0] id_full;

    always #5 clk = ~clk;

    ow_rom_slave #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit),
        .irq_pending(irq_pending), .grant(grant)
    );

    // {cmd[7:0], irq, expected grant, expected tx_bit}
    localparam logic [10:0] VECS [0:6] = '{
        {8'hCC, 1'b0, 1'b1, 1'b1},
        {8'h33, 1'b0, 1'b0, 1'b0},
        {8'hF0, 1'b0, 1'b0, 1'b0},
        {8'hEC, 1'b1, 1'b0, 1'b0},
        {8'hEC, 1'b0, 1'b0, 1'b1},
        {8'h55, 1'b0, 1'b0, 1'b1},
        {8'hA5, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_bus_reset();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin rx_valid = 1'b1; rx_bit = b; end
        @(negedge clk) rx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic read_slot(output logic b);
        @(negedge clk) begin b = tx_bit; tx_req = 1'b1; end
        @(negedge clk) tx_req = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] tb_crc(input logic [63:0] d, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic f = c[0] ^ d[i];
            c = {1'b0, c[7:1]};
            if (f) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic b;
        logic [63:0] got;
        id_full = {8'h00, SER, FAM};
        id_full[63:56] = tb_crc(id_full, 56);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R10 reset state
        check(grant == 1'b0, "R1 grant after reset", 64'(grant), 0);
        check(tx_bit == 1'b1, "R10 tx released after reset", 64'(tx_bit), 1);

        // table walk: R3 R6 R8 R9
        for (int v = 0; v < 7; v++) begin
            do_bus_reset();
            irq_pending = VECS[v][2];
            send_byte(VECS[v][10:3]);
            check(grant == VECS[v][1], "R3 table grant", 64'(grant), 64'(VECS[v][1]));
            check(tx_bit == VECS[v][0], "R3 table tx_bit", 64'(tx_bit), 64'(VECS[v][0]));
        end
        irq_pending = 1'b0;

        // R4 read identifier, R2 layout and CRC
        do_bus_reset();
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) begin
            read_slot(b);
            got[i] = b;
        end
        check(got == id_full, "R4 identifier bits", got, id_full);
        check(got[7:0] == 8'h04, "R2 family code", 64'(got[7:0]), 64'h04);
        check(tb_crc(got, 64) == 8'h00, "R2 crc residue", 64'(tb_crc(got, 64)), 0);
        check(grant == 1'b1, "R4 grant after read", 64'(grant), 1);

        // R5 match success, R11 grant hold, R1 reset clears
        do_bus_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(id_full[i]);
        check(grant == 1'b1, "R5 match grant", 64'(grant), 1);
        send_byte(8'h00);
        read_slot(b);
        check(grant == 1'b1, "R11 grant kept", 64'(grant), 1);
        check(b == 1'b1, "R10 granted read slot", 64'(b), 1);
        do_bus_reset();
        check(grant == 1'b0, "R1 bus reset drops grant", 64'(grant), 0);

        // R5 mismatch at bit 40
        send_byte(8'h55);
        for (int i = 0; i < 41; i++) send_bit(i == 40 ? ~id_full[i] : id_full[i]);
        for (int i = 41; i < 64; i++) send_bit(id_full[i]);
        check(grant == 1'b0, "R5 mismatch no grant", 64'(grant), 0);
        send_byte(8'hCC);
        check(grant == 1'b0, "R9 silent ignores bits", 64'(grant), 0);

        // R7 full search
        do_bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            logic t, c;
            read_slot(t);
            read_slot(c);
            if (t != id_full[i] || c != ~id_full[i]) begin
                check(1'b0, "R7 search pair", {62'b0, t, c}, {62'b0, id_full[i], ~id_full[i]});
            end
            send_bit(id_full[i]);
        end
        check(grant == 1'b1, "R7 search grant", 64'(grant), 1);

        // R7 search drop at bit 5
        do_bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 6; i++) begin
            read_slot(b);
            read_slot(b);
            send_bit(i == 5 ? ~id_full[i] : id_full[i]);
        end
        read_slot(b);
        check(b == 1'b1, "R7 dropped reads one", 64'(b), 1);
        check(grant == 1'b0, "R7 dropped no grant", 64'(grant), 0);

        // R8 conditional search, irq removed at bit 3
        do_bus_reset();
        irq_pending = 1'b1;
        send_byte(8'hEC);
        for (int i = 0; i < 3; i++) begin
            read_slot(b);
            read_slot(b);
            send_bit(id_full[i]);
        end
        read_slot(b);
        check(b == id_full[3], "R8 cond search active", 64'(b), 64'(id_full[3]));
        irq_pending = 1'b0;
        @(negedge clk);
        @(negedge clk);
        read_slot(b);
        check(b == 1'b1, "R8 cond search drops", 64'(b), 1);

        // R8 conditional search completes with irq held
        do_bus_reset();
        irq_pending = 1'b1;
        send_byte(8'hEC);
        for (int i = 0; i < 64; i++) begin
            read_slot(b);
            read_slot(b);
            send_bit(id_full[i]);
        end
        check(grant == 1'b1, "R8 cond search grant", 64'(grant), 1);
        irq_pending = 1'b0;

        // R1 bus reset mid-command discards partial byte
        do_bus_reset();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        do_bus_reset();
        send_byte(8'hCC);
        check(grant == 1'b1, "R1 partial command discarded", 64'(grant), 1);

        // R9 unknown command then skip stays silent
        do_bus_reset();
        send_byte(8'h3C);
        send_byte(8'hCC);
        check(grant == 1'b0, "R9 unknown command silent", 64'(grant), 0);
        read_slot(b);
        check(b == 1'b1, "R10 silent read slot", 64'(b), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule